// File: doc/BRIEF.md
# Serial Folded Linear-Phase FIR Filter

This block is a streaming FIR filter whose coefficient set is symmetric about its centre. It takes one signed sample at a time through a valid/ready handshake and returns exactly one filtered sample for each one it accepts. It does not produce the longer full-convolution result. One multiplier serves every tap. Because tap k and tap TAPS-1-k share a coefficient, the two delayed samples for a pair are added before the multiply. A full output therefore takes TAPS/2 multiply-accumulate cycles rather than TAPS.

Samples are kept in a circular buffer that a write pointer addresses. The block also keeps a count of the samples received since reset, and any position older than that count reads as zero. A reset therefore clears the history without touching the storage. The half-table of coefficients is cleared by reset and written through a simple port while the filter is idle. The full-precision sum is rounded by a right shift, chosen per sample, and saturated to the sample width.

Top module: `fir_fold_serial`

## Requirements
- R1: `inReady` is high only when the filter is idle. After a sample is accepted it stays low until the result has been taken with `outReady`, and `inReady` and `outValid` are never high together.
- R2: For the n-th accepted sample, the result is sum over k=0..TAPS/2-1 of c[k]*(x[n-k] + x[n-(TAPS-1-k)]). Table entry k is the weight of both tap k and tap TAPS-1-k.
- R3: Samples accepted before the most recent reset contribute zero to every later result.
- R4: With c[0]=2, c[1]=1, c[2]=4, all other entries 0, a shift of 0, and inputs 1, 2, 3 after reset, the first three results are 2, 5 and 12.
- R5: The sum is rounded by adding 2^(s-1) when s>0 and then shifting arithmetically right by s, which rounds ties toward plus infinity. s is the `shiftAmt` value captured when the sample is accepted.
- R6: A rounded value above 32767 is output as 32767, and one below -32768 is output as -32768.
- R7: A write with `coefWe`=1 stores `coefData` into entry `coefAddr` (0..TAPS/2-1) only while the filter is idle with no result pending. A write while a sample is in progress is ignored.
- R8: After reset, `outValid`=0, `inReady`=1 and every coefficient entry is 0.
- R9: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` does not change.
- R10: `outValid` rises on the TAPS/2+1-th rising edge after the edge that accepts a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input sample offered |
| inReady | output | 1 | Filter idle, sample will be taken |
| inData | input | DW | Signed input sample |
| shiftAmt | input | SHW | Right shift applied to this sample's sum |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Result taken |
| outData | output | DW | Signed rounded, saturated result |
| coefWe | input | 1 | Coefficient write strobe |
| coefAddr | input | TW | Coefficient half-table index |
| coefData | input | CW | Signed coefficient value |

## Verification
On every cycle, the bound checker watches three protocol properties: the handshake exclusion and ready drop, the stability of a held result, and the exact accept-to-result latency. The arithmetic cannot be seen from a single cycle. The folded tap pairing, history masking after reset, rounding ties, saturation, and the rejection of writes made mid-computation are shown only by the bench. It drives directed cases and a long seeded random run that wraps the circular buffer, and compares each result against a direct convolution model.

// File: rtl/fir_fold_pkg.sv
package fir_fold_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic takeSample;  // write newest sample, advance pointer
    logic clrAcc;      // zero the accumulator
    logic macEn;       // accumulate one folded pair
    logic finish;      // round, saturate and register result
    logic coefWrOk;    // table may be written
  } firStrobes_t;
endpackage

// File: rtl/fir_fold_ctrl.sv
module fir_fold_ctrl
  import fir_fold_pkg::*;
#(
  parameter int HALF = 128,
  localparam int TW = $clog2(HALF)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output logic          inReady,
  input  logic          outReady,
  output logic          outValid,
  output firStrobes_t   strobes,
  output logic [TW-1:0] tapIdx
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN, S_HOLD} seqState_t;
  seqState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      tapIdx <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (inValid) begin
          state  <= S_RUN;
          tapIdx <= '0;
        end
        S_RUN: begin
          tapIdx <= tapIdx + TW'(1);
          if (tapIdx == TW'(HALF - 1)) state <= S_FIN;
        end
        S_FIN:  state <= S_HOLD;
        S_HOLD: if (outReady) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    inReady             = (state == S_IDLE);
    outValid            = (state == S_HOLD);
    strobes.takeSample  = inReady && inValid;
    strobes.clrAcc      = inReady && inValid;
    strobes.macEn       = (state == S_RUN);
    strobes.finish      = (state == S_FIN);
    strobes.coefWrOk    = (state == S_IDLE);
  end
endmodule

// File: rtl/fir_fold_path.sv
module fir_fold_path
  import fir_fold_pkg::*;
#(
  parameter int TAPS = 256,
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int SHW  = 6,
  localparam int HALF = TAPS / 2,
  localparam int TW   = $clog2(HALF),
  localparam int PW   = $clog2(TAPS),
  localparam int PSW  = DW + 1,
  localparam int PRW  = PSW + CW,
  localparam int ACCW = PRW + TW
) (
  input  logic           clk,
  input  logic           rstN,
  input  firStrobes_t    strobes,
  input  logic [TW-1:0]  tapIdx,
  input  logic [DW-1:0]  inData,
  input  logic [SHW-1:0] shiftAmt,
  input  logic           coefWe,
  input  logic [TW-1:0]  coefAddr,
  input  logic [CW-1:0]  coefData,
  output logic [DW-1:0]  outData
);
  localparam logic signed [ACCW:0] MAXV = (ACCW+1)'(2 ** (DW - 1) - 1);
  localparam logic signed [ACCW:0] MINV = -MAXV - 1;
  localparam logic [PW-1:0] LASTAGE = PW'(TAPS - 1);

  logic signed [DW-1:0]   sampleMem [TAPS];
  logic signed [CW-1:0]   coefTab [HALF];
  logic [PW-1:0]          wrPtr;
  logic [PW:0]            histCnt;
  logic [SHW-1:0]         shiftReg;
  logic signed [ACCW-1:0] acc;

  logic [PW-1:0]          ageA, ageB, idxA, idxB;
  logic signed [DW-1:0]   smpA, smpB;
  logic signed [PSW-1:0]  preSum;
  logic signed [PRW-1:0]  prod;
  logic signed [ACCW:0]   rndBias, biased, shifted;

  // sample storage: no reset, stale entries are masked by histCnt
  always_ff @(posedge clk) begin
    if (strobes.takeSample) sampleMem[wrPtr + PW'(1)] <= inData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      histCnt  <= '0;
      shiftReg <= '0;
    end else if (strobes.takeSample) begin
      wrPtr    <= wrPtr + PW'(1);
      shiftReg <= shiftAmt;
      if (histCnt != (PW+1)'(TAPS)) histCnt <= histCnt + (PW+1)'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < HALF; i++) coefTab[i] <= '0;
    end else if (coefWe && strobes.coefWrOk) begin
      coefTab[coefAddr] <= coefData;
    end
  end

  // folded pair: newest-side tap and its mirror
  always_comb begin
    ageA   = PW'(tapIdx);
    ageB   = LASTAGE - ageA;
    idxA   = wrPtr - ageA;
    idxB   = wrPtr - ageB;
    smpA   = ({1'b0, ageA} < histCnt) ? sampleMem[idxA] : '0;
    smpB   = ({1'b0, ageB} < histCnt) ? sampleMem[idxB] : '0;
    preSum = PSW'(smpA) + PSW'(smpB);
    prod   = PRW'(preSum) * PRW'(coefTab[tapIdx]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                acc <= '0;
    else if (strobes.clrAcc)  acc <= '0;
    else if (strobes.macEn)   acc <= acc + ACCW'(prod);
  end

  // round half up, then clamp to the sample range
  always_comb begin
    rndBias = (shiftReg == '0) ? '0 : ((ACCW+1)'(1) << (shiftReg - SHW'(1)));
    biased  = (ACCW+1)'(acc) + rndBias;
    shifted = biased >>> shiftReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outData <= '0;
    else if (strobes.finish) begin
      if (shifted > MAXV)      outData <= DW'(MAXV);
      else if (shifted < MINV) outData <= DW'(MINV);
      else                     outData <= DW'(shifted);
    end
  end
endmodule

// File: rtl/fir_fold_serial.sv
module fir_fold_serial
  import fir_fold_pkg::*;
#(
  parameter int TAPS = 256,
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int SHW  = 6,
  localparam int TW  = $clog2(TAPS / 2)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  output logic           inReady,
  input  logic [DW-1:0]  inData,
  input  logic [SHW-1:0] shiftAmt,
  output logic           outValid,
  input  logic           outReady,
  output logic [DW-1:0]  outData,
  input  logic           coefWe,
  input  logic [TW-1:0]  coefAddr,
  input  logic [CW-1:0]  coefData
);
  firStrobes_t   strobes;
  logic [TW-1:0] tapIdx;

  fir_fold_ctrl #(.HALF(TAPS / 2)) seqU (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outReady(outReady), .outValid(outValid), .strobes(strobes), .tapIdx(tapIdx)
  );

  fir_fold_path #(.TAPS(TAPS), .DW(DW), .CW(CW), .SHW(SHW)) pathU (
    .clk(clk), .rstN(rstN), .strobes(strobes), .tapIdx(tapIdx),
    .inData(inData), .shiftAmt(shiftAmt), .coefWe(coefWe),
    .coefAddr(coefAddr), .coefData(coefData), .outData(outData)
  );
endmodule

// File: rtl/fir_fold_serial_chk.sv
module fir_fold_serial_chk #(
  parameter int HALF = 128,
  parameter int DW   = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic          inReady,
  input logic          outValid,
  input logic          outReady,
  input logic [DW-1:0] outData
);
  logic [15:0] sinceAccept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sinceAccept <= '0;
    else if (inValid && inReady) sinceAccept <= '0;
    else if (!outValid)         sinceAccept <= sinceAccept + 16'd1;
  end

  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));

  assert_result_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (sinceAccept == 16'(HALF + 1)));
endmodule

bind fir_fold_serial fir_fold_serial_chk #(.HALF(TAPS / 2), .DW(DW)) chkU (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outData(outData)
);

// File: tb/fir_fold_serial_test.sv
module fir_fold_serial_test;
  localparam int TAPS = 256;
  localparam int HALF = TAPS / 2;
  localparam int DW = 16, CW = 16, SHW = 6;
  localparam int TW = $clog2(HALF);

  logic clk = 0, rstN = 0, inValid = 0, outReady = 0, coefWe = 0;
  logic inReady, outValid;
  logic [DW-1:0]  inData = '0, outData;
  logic [SHW-1:0] shiftAmt = '0;
  logic [TW-1:0]  coefAddr = '0;
  logic [CW-1:0]  coefData = '0;

  always #10 clk = ~clk;

  fir_fold_serial #(.TAPS(TAPS), .DW(DW), .CW(CW), .SHW(SHW)) uut (.*);

  int checks = 0, errors = 0;
  int coefModel [HALF];
  int histQ [$];

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int xAt(int age);
    int n = histQ.size();
    return (age < n) ? histQ[n - 1 - age] : 0;
  endfunction

  function automatic longint expectY(int sh);
    longint s = 0;
    for (int k = 0; k < HALF; k++)
      s += longint'(coefModel[k]) * (longint'(xAt(k)) + longint'(xAt(TAPS - 1 - k)));
    if (sh > 0) s += (64'sd1 <<< (sh - 1));
    s = s >>> sh;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 0; inValid = 0; outReady = 0; coefWe = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    histQ.delete();
    for (int k = 0; k < HALF; k++) coefModel[k] = 0;
  endtask

  task automatic writeCoef(int a, int v);
    @(negedge clk);
    coefWe = 1; coefAddr = TW'(a); coefData = CW'(v);
    @(negedge clk);
    coefWe = 0;
    coefModel[a] = int'($signed(CW'(v)));
  endtask

  task automatic runSample(int x, int sh, bit busyWrite, int hold, string req, output int got);
    int lat;
    longint exp;
    @(negedge clk);
    inValid = 1; inData = DW'(x); shiftAmt = SHW'(sh);
    @(posedge clk);
    histQ.push_back(int'($signed(DW'(x))));
    exp = expectY(sh);
    @(negedge clk);
    inValid = 0;
    check(!inReady, "R1", longint'(inReady), 0);
    lat = 0;
    while (1) begin
      if (busyWrite && lat == 0) begin
        coefWe = 1; coefAddr = '0; coefData = 16'h0123;   // R7 ignored write
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
      coefWe = 0;
      if (outValid || lat > 1000) break;
    end
    check(lat == HALF + 1, "R10", lat, HALF + 1);
    got = int'($signed(outData));
    check(longint'(got) == exp, req, got, exp);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(outValid && int'($signed(outData)) == got, "R9", int'($signed(outData)), got);
    end
    outReady = 1;
    @(negedge clk);
    outReady = 0;
    check(!outValid && inReady, "R1", longint'({outValid, inReady}), 1);
  endtask

  task automatic runAll();
    int got;
    void'($urandom(32'd7411));
    doReset();
    check(!outValid && inReady, "R8", longint'({outValid, inReady}), 1);
    runSample(500, 0, 0, 0, "R8", got);              // all coefficients zero

    // R4 streaming example
    doReset();
    writeCoef(0, 2); writeCoef(1, 1); writeCoef(2, 4);
    runSample(1, 0, 0, 1, "R4", got); check(got == 2, "R4", got, 2);
    runSample(2, 0, 0, 0, "R4", got); check(got == 5, "R4", got, 5);
    runSample(3, 0, 0, 2, "R4", got); check(got == 12, "R4", got, 12);

    // R5 rounding ties and shifts
    doReset();
    writeCoef(0, 1);
    runSample(3, 1, 0, 0, "R5", got);  check(got == 2, "R5", got, 2);
    runSample(-3, 1, 0, 0, "R5", got); check(got == -1, "R5", got, -1);
    runSample(5, 2, 0, 0, "R5", got);  check(got == 1, "R5", got, 1);
    runSample(6, 2, 0, 0, "R5", got);  check(got == 2, "R5", got, 2);

    // R6 saturation both ways
    writeCoef(0, 32767);
    runSample(32767, 0, 0, 0, "R6", got);  check(got == 32767, "R6", got, 32767);
    runSample(-32768, 0, 0, 0, "R6", got); check(got == -32768, "R6", got, -32768);

    // R7 write during computation is dropped; old weight still used
    runSample(100, 0, 1, 0, "R7", got);
    runSample(1, 0, 0, 0, "R7", got); check(got == 32767, "R7", got, 32767);

    // R3 history cleared by reset
    doReset();
    for (int k = 0; k < HALF; k++) writeCoef(k, 1);
    for (int i = 0; i < 5; i++) runSample(1000 + i, 0, 0, 0, "R2", got);
    doReset();
    for (int k = 0; k < HALF; k++) writeCoef(k, 1);
    runSample(10, 0, 0, 0, "R3", got); check(got == 10, "R3", got, 10);
    runSample(-4, 0, 0, 0, "R3", got); check(got == 6, "R3", got, 6);

    // R2 random run past a full buffer wrap
    doReset();
    for (int k = 0; k < HALF; k++) writeCoef(k, int'($urandom_range(600)) - 300);
    for (int i = 0; i < 300; i++)
      runSample(int'($urandom_range(65535)) - 32768, int'($urandom_range(12)) + 8,
                0, int'($urandom_range(2)), "R2", got);
    for (int k = 0; k < HALF; k++) writeCoef(k, int'($urandom_range(65535)) - 32768);
    for (int i = 0; i < 40; i++)
      runSample(int'($urandom_range(65535)) - 32768, int'($urandom_range(14)) + 14,
                0, 0, "R2", got);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule